// File: doc/BRIEF.md
# Two-Owner Hardware Mutex Bank

This block keeps a bank of lock bits shared by two processors. Each processor has its own command port and its own register read port, and the port a command arrives on identifies the requester. A processor asks for a bit by writing its index with a lock command, then reads its result register to learn whether the lock was granted. It gives the bit back later with a release command. Only the holder of a bit may release it. Either processor can read a mask of the bits that are locked and a mask of which processor owns each of them.

Commands are single-cycle strobes. A command presented with its valid high at a rising clock edge is decided against the state held before that edge. The lock state, the owner state and the per-port result registers all update at that same edge. When both ports hit the same free bit in one cycle, the decision is made atomically and exactly one port wins.

Top module: `dual_mutex_bank`

## Requirements
- R1: After reset every bit is unlocked, the locked mask and the owner mask read 0, and both result registers read 0.
- R2: A lock command (`xCmdRel`=0) on a free bit is granted. One cycle later that port's result reads 1, the bit is set in the locked mask, and the owner mask bit is 0 for port A or 1 for port B.
- R3: A lock command on a bit held by the other port is refused. The result reads 0 and neither mask changes.
- R4: A lock command on a bit the requester already holds reports 1 and changes neither mask.
- R5: A release command (`xCmdRel`=1) from the holder clears the bit in both masks and reports 1.
- R6: A release command from the port that does not hold the bit, or on a free bit, reports 0 and leaves both masks unchanged.
- R7: If both ports request a lock on the same free bit in the same cycle, port A is granted and port B reads 0.
- R8: Commands from the two ports on different bits in the same cycle both take effect. Every decision uses the state from before that cycle, so a lock by one port on a bit the other port releases in that same cycle is refused.
- R9: Each read port is combinational from the registers. Select 0 gives the port's result in bit 0, select 1 gives the locked mask, select 2 gives the owner mask, and select 3 gives 0.
- R10: A result register keeps its value until the next command on its own port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| aCmdValid | input | 1 | Port A command strobe |
| aCmdRel | input | 1 | Port A command kind: 0 lock, 1 release |
| aCmdIdx | input | 5 | Port A bit index |
| aRdSel | input | 2 | Port A register select |
| aRdData | output | 32 | Port A read data |
| bCmdValid | input | 1 | Port B command strobe |
| bCmdRel | input | 1 | Port B command kind: 0 lock, 1 release |
| bCmdIdx | input | 5 | Port B bit index |
| bRdSel | input | 2 | Port B register select |
| bRdData | output | 32 | Port B read data |

## Verification
The hardest cases to reach from the ports are the same-cycle collisions. In one, both ports lock the same free bit. In another, one port releases a bit while the other tries to lock it. Neither happens unless both command strobes rise on the same edge with matching indices. The driver task therefore takes a full pair of port commands per call. This lets the bench line up same-bit contention, a release against a lock, and independent operations on different bits, each in a single cycle. It then sweeps every index with alternating owners so that each bit position is exercised.

// File: rtl/mutex_bank_pkg.sv
package mutex_bank_pkg;
  parameter int unsigned LOCK_COUNT = 32;
  localparam int unsigned IDX_W = $clog2(LOCK_COUNT);
  localparam int unsigned DATA_W = 32;
  localparam int unsigned SEL_W = 2;

  typedef logic [LOCK_COUNT-1:0] lockVec_t;

  typedef struct packed {
    logic             valid;
    logic             rel;
    logic [IDX_W-1:0] idx;
  } cmd_t;

  // strobes from control to datapath
  typedef struct packed {
    lockVec_t setA;
    lockVec_t setB;
    lockVec_t clr;
    logic     loadA;
    logic     grantA;
    logic     loadB;
    logic     grantB;
  } strobe_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_RESULT = 2'd0,
    SEL_LOCKED = 2'd1,
    SEL_OWNER  = 2'd2,
    SEL_NONE   = 2'd3
  } rdSel_e;
endpackage

// File: rtl/mutex_ctrl.sv
module mutex_ctrl
  import mutex_bank_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  cmd_t     cmdA,
  input  cmd_t     cmdB,
  input  lockVec_t lockedQ,
  input  lockVec_t ownerQ,
  output strobe_t  strobe
);
  lockVec_t decA, decB;
  logic aLock, aRel, bLock, bRel;
  logic heldA, heldB, byB_A, byB_B, sameIdx;
  logic grantA, grantB;

  // one-hot decode of each port's index
  for (genvar i = 0; i < LOCK_COUNT; i++) begin : g_dec
    assign decA[i] = cmdA.valid && (cmdA.idx == IDX_W'(i));
    assign decB[i] = cmdB.valid && (cmdB.idx == IDX_W'(i));
  end

  assign aLock   = cmdA.valid && !cmdA.rel;
  assign aRel    = cmdA.valid &&  cmdA.rel;
  assign bLock   = cmdB.valid && !cmdB.rel;
  assign bRel    = cmdB.valid &&  cmdB.rel;
  assign heldA   = lockedQ[cmdA.idx];
  assign heldB   = lockedQ[cmdB.idx];
  assign byB_A   = ownerQ[cmdA.idx];
  assign byB_B   = ownerQ[cmdB.idx];
  assign sameIdx = (cmdA.idx == cmdB.idx);

  always_comb begin
    // port A has priority on a contended free bit
    if (aLock) grantA = !heldA || !byB_A;
    else       grantA = heldA && !byB_A;
    if (bLock) grantB = (!heldB && !(aLock && sameIdx)) || (heldB && byB_B);
    else       grantB = heldB && byB_B;
  end

  always_comb begin
    strobe        = '0;
    strobe.loadA  = cmdA.valid;
    strobe.grantA = grantA;
    strobe.loadB  = cmdB.valid;
    strobe.grantB = grantB;
    if (aLock && !heldA)           strobe.setA = decA;
    if (bLock && grantB && !heldB) strobe.setB = decB;
    if (aRel && grantA)            strobe.clr  = strobe.clr | decA;
    if (bRel && grantB)            strobe.clr  = strobe.clr | decB;
  end

  AST_ONE_SETTER: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setA & strobe.setB) == '0); // R7
  AST_CLR_ONLY_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clr & ~lockedQ) == '0); // R6
  AST_SET_ONLY_FREE: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.setA | strobe.setB) & lockedQ) == '0); // R4
endmodule

// File: rtl/mutex_datapath.sv
module mutex_datapath
  import mutex_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [SEL_W-1:0]  aRdSel,
  input  logic [SEL_W-1:0]  bRdSel,
  output lockVec_t          lockedQ,
  output lockVec_t          ownerQ,
  output logic [DATA_W-1:0] aRdData,
  output logic [DATA_W-1:0] bRdData
);
  logic resA, resB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockedQ <= '0;
      ownerQ  <= '0;
      resA    <= 1'b0;
      resB    <= 1'b0;
    end else begin
      lockedQ <= (lockedQ & ~strobe.clr) | strobe.setA | strobe.setB;
      ownerQ  <= (ownerQ & ~strobe.clr & ~strobe.setA) | strobe.setB;
      if (strobe.loadA) resA <= strobe.grantA;
      if (strobe.loadB) resB <= strobe.grantB;
    end
  end

  function automatic logic [DATA_W-1:0] readMux(logic [SEL_W-1:0] sel, logic res,
                                                lockVec_t lk, lockVec_t ow);
    case (rdSel_e'(sel))
      SEL_RESULT: return DATA_W'(res);
      SEL_LOCKED: return DATA_W'(lk);
      SEL_OWNER:  return DATA_W'(ow);
      default:    return '0;
    endcase
  endfunction

  assign aRdData = readMux(aRdSel, resA, lockedQ, ownerQ);
  assign bRdData = readMux(bRdSel, resB, lockedQ, ownerQ);

  AST_OWNER_HAS_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (ownerQ & ~lockedQ) == '0); // R2
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadA |=> $stable(resA)); // R10
endmodule

// File: rtl/dual_mutex_bank.sv
module dual_mutex_bank
  import mutex_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              aCmdValid,
  input  logic              aCmdRel,
  input  logic [IDX_W-1:0]  aCmdIdx,
  input  logic [SEL_W-1:0]  aRdSel,
  output logic [DATA_W-1:0] aRdData,
  input  logic              bCmdValid,
  input  logic              bCmdRel,
  input  logic [IDX_W-1:0]  bCmdIdx,
  input  logic [SEL_W-1:0]  bRdSel,
  output logic [DATA_W-1:0] bRdData
);
  cmd_t     cmdA, cmdB;
  strobe_t  strobe;
  lockVec_t lockedQ, ownerQ;

  assign cmdA = '{valid: aCmdValid, rel: aCmdRel, idx: aCmdIdx};
  assign cmdB = '{valid: bCmdValid, rel: bCmdRel, idx: bCmdIdx};

  mutex_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdA(cmdA), .cmdB(cmdB),
    .lockedQ(lockedQ), .ownerQ(ownerQ), .strobe(strobe)
  );

  mutex_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .aRdSel(aRdSel), .bRdSel(bRdSel),
    .lockedQ(lockedQ), .ownerQ(ownerQ),
    .aRdData(aRdData), .bRdData(bRdData)
  );

  AST_A_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (aCmdValid && !aCmdRel && bCmdValid && !bCmdRel && aCmdIdx == bCmdIdx && !lockedQ[aCmdIdx])
    |=> lockedQ[$past(aCmdIdx)] && !ownerQ[$past(aCmdIdx)]); // R7
  AST_FOREIGN_REL_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (bCmdValid && bCmdRel && lockedQ[bCmdIdx] && !ownerQ[bCmdIdx]
     && !(aCmdValid && aCmdRel && aCmdIdx == bCmdIdx))
    |=> lockedQ[$past(bCmdIdx)] && !ownerQ[$past(bCmdIdx)]); // R6
endmodule

// File: tb/dual_mutex_bank_bench.sv
module dual_mutex_bank_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aCmdValid = 0, aCmdRel = 0, bCmdValid = 0, bCmdRel = 0;
  logic [4:0] aCmdIdx = 0, bCmdIdx = 0;
  logic [1:0] aRdSel = 0, bRdSel = 0;
  logic [31:0] aRdData, bRdData;

  int errors = 0;
  int checks = 0;

  typedef struct {
    bit    expA;
    bit    expB;
    bit [31:0] lk;
    bit [31:0] ow;
    string tag;
  } item_t;
  item_t q[$];

  bit [31:0] mLk = 0, mOw = 0;
  bit mResA = 0, mResB = 0;

  always #5 clk = ~clk;

  dual_mutex_bank u_dual_mutex_bank (
    .clk(clk), .rstN(rstN),
    .aCmdValid(aCmdValid), .aCmdRel(aCmdRel), .aCmdIdx(aCmdIdx),
    .aRdSel(aRdSel), .aRdData(aRdData),
    .bCmdValid(bCmdValid), .bCmdRel(bCmdRel), .bCmdIdx(bCmdIdx),
    .bRdSel(bRdSel), .bRdData(bRdData)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: compute expectation from the requirements, push it, drive one cycle
  task automatic issue(bit av, bit ar, int ai, bit bv, bit br, int bi, string tag);
    bit ga, gb;
    bit [31:0] nLk, nOw;
    ga = 0; gb = 0;
    nLk = mLk; nOw = mOw;
    if (av) begin
      if (!ar) ga = !mLk[ai] || !mOw[ai];
      else     ga = mLk[ai] && !mOw[ai];
    end
    if (bv) begin
      if (!br) gb = (!mLk[bi] && !(av && !ar && ai == bi)) || (mLk[bi] && mOw[bi]);
      else     gb = mLk[bi] && mOw[bi];
    end
    if (av && ga) begin
      if (ar) begin nLk[ai] = 0; nOw[ai] = 0; end
      else if (!mLk[ai]) begin nLk[ai] = 1; nOw[ai] = 0; end
    end
    if (bv && gb) begin
      if (br) begin nLk[bi] = 0; nOw[bi] = 0; end
      else if (!mLk[bi]) begin nLk[bi] = 1; nOw[bi] = 1; end
    end
    mLk = nLk; mOw = nOw;
    if (av) mResA = ga;
    if (bv) mResB = gb;
    @(negedge clk);
    aCmdValid = av; aCmdRel = ar; aCmdIdx = 5'(ai);
    bCmdValid = bv; bCmdRel = br; bCmdIdx = 5'(bi);
    @(posedge clk);
    #1;
    aCmdValid = 0; bCmdValid = 0;
    q.push_back('{expA: mResA, expB: mResB, lk: mLk, ow: mOw, tag: tag});
    wait (q.size() == 0);
  endtask

  // monitor: pops expectations and compares through the read ports
  initial begin
    forever begin
      item_t it;
      wait (q.size() > 0);
      it = q.pop_front();
      aRdSel = 2'd0; bRdSel = 2'd0; #1;
      check(it.tag, "resultA", aRdData, {31'b0, it.expA});
      check(it.tag, "resultB", bRdData, {31'b0, it.expB});
      aRdSel = 2'd1; bRdSel = 2'd2; #1;
      check(it.tag, "lockedA", aRdData, it.lk);
      check(it.tag, "ownerB", bRdData, it.ow);
      aRdSel = 2'd2; bRdSel = 2'd1; #1;
      check({it.tag, " R9"}, "ownerA", aRdData, it.ow);
      check({it.tag, " R9"}, "lockedB", bRdData, it.lk);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R1 reset state
    aRdSel = 0; bRdSel = 0; #1;
    check("R1", "resultA", aRdData, 0);
    check("R1", "resultB", bRdData, 0);
    aRdSel = 1; bRdSel = 2; #1;
    check("R1", "locked", aRdData, 0);
    check("R1", "owner", bRdData, 0);
    aRdSel = 3; bRdSel = 3; #1;
    check("R9", "selNoneA", aRdData, 0);
    check("R9", "selNoneB", bRdData, 0);

    issue(1, 0, 3, 0, 0, 0, "R2 A locks free");
    issue(0, 0, 0, 1, 0, 3, "R3 B locks A-held");
    issue(1, 0, 3, 0, 0, 0, "R4 A relocks own");
    issue(0, 0, 0, 1, 1, 3, "R6 B releases A-held");
    issue(0, 0, 0, 1, 0, 7, "R2 B locks free");
    issue(1, 1, 7, 0, 0, 0, "R6 A releases B-held");
    issue(0, 0, 0, 1, 0, 7, "R4 B relocks own");
    issue(0, 0, 0, 1, 1, 7, "R5 B releases own");
    issue(1, 1, 20, 0, 0, 0, "R6 A releases free");
    issue(1, 0, 12, 1, 0, 12, "R7 same-bit contention");
    issue(1, 0, 0, 1, 0, 31, "R8 different bits");
    issue(1, 1, 3, 1, 0, 3, "R8 release vs lock");
    issue(0, 0, 0, 0, 0, 0, "R10 idle holds results");
    issue(1, 1, 12, 1, 1, 31, "R5 both release");
    for (int i = 0; i < 32; i++) begin
      if (i % 2 == 0) issue(1, 0, i, 0, 0, 0, "R2 sweep A");
      else            issue(0, 0, 0, 1, 0, i, "R2 sweep B");
    end
    for (int i = 0; i < 32; i++) begin
      issue(1, 1, i, 1, 1, i, "R5 sweep release");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule